// File: doc/BRIEF.md
# Thread-Group SIMD Issue Sequencer

This block sits inside one sub-core of a throughput processor. It tracks up to sixteen thread groups of 32 lanes each. Each group offers a ready flag, the kind of its current instruction and a 32-bit active mask. Lanes cleared in the mask sit on a different control path and must not produce results.

Every cycle the sequencer accepts at most one ready group. It chooses among the eligible groups in round-robin order. It then streams that group's instruction through the functional unit for its kind. There are three units: an integer unit and an fp32 unit, each 16 lanes wide, and an fp64 unit that is 8 lanes wide. A 32-lane instruction therefore takes 2 beats on a 16-wide unit and 4 beats on the 8-wide unit. For every beat the sequencer presents the lane offset of that slice and the slice of the active mask that enables those lanes.

The three units run side by side. Instructions of different kinds that are accepted in consecutive cycles overlap in time. Register files and the arithmetic itself live outside this block.

Top module: `simd_issue_seq`

## Requirements
- R1: After reset every unit output reports no valid beat, and no group is accepted while no group is ready.
- R2: Kind code 0 (integer) and kind code 1 (fp32) each issue on their own 16-wide unit. If a group is accepted in cycle t, the unit shows beat k (k = 0, 1) in cycle t+1+k, with lane offset 16*k and lane enables equal to mask bits [16k+15:16k].
- R3: Kind code 2 (fp64) issues on the 8-wide unit over 4 beats, k = 0 to 3. Beat k is shown in cycle t+1+k, with lane offset 8*k and lane enables equal to mask bits [8k+7:8k].
- R4: A beat whose lane slice is entirely masked off is still spent. Valid stays high with all lane enables zero, so the beat count does not depend on the mask.
- R5: A group can be accepted only when the unit for its kind is idle or is showing its final beat. Instructions on one unit follow each other with no gap.
- R6: Among eligible groups, the one accepted is the first found when searching upward, with wrap-around, from the group after the one last accepted. After reset the search starts at group 0.
- R7: A group cannot be accepted again while its previous instruction is in any beat other than the final beat.
- R8: The accept vector `grp_take` is zero or one-hot, and it only marks a group whose ready flag is high. It changes in the same cycle as the inputs.
- R9: A group whose kind code is 3 is never accepted.
- R10: Units of different kinds run concurrently, so an fp64 instruction and an integer instruction can show beats in the same cycle.
- R11: Each unit's group output names the group whose instruction that unit is currently sequencing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_ready | input | NUM_GROUPS | Per-group instruction-ready flag |
| grp_kind | input | 2*NUM_GROUPS | Per-group kind code, bits [2g+1:2g]: 0 integer, 1 fp32, 2 fp64, 3 reserved |
| grp_mask | input | LANES*NUM_GROUPS | Per-group active mask, bits [32g+31:32g] |
| grp_take | output | NUM_GROUPS | One-hot accept of the chosen group in this cycle |
| int_valid | output | 1 | Integer unit shows a beat |
| int_group | output | GW | Group on the integer unit |
| int_lane_en | output | WIDE_W | Lane enables of the integer beat |
| int_lane_base | output | LW | First lane number of the integer beat |
| f32_valid | output | 1 | fp32 unit shows a beat |
| f32_group | output | GW | Group on the fp32 unit |
| f32_lane_en | output | WIDE_W | Lane enables of the fp32 beat |
| f32_lane_base | output | LW | First lane number of the fp32 beat |
| f64_valid | output | 1 | fp64 unit shows a beat |
| f64_group | output | GW | Group on the fp64 unit |
| f64_lane_en | output | NARROW_W | Lane enables of the fp64 beat |
| f64_lane_base | output | LW | First lane number of the fp64 beat |

## Verification
Directed cases come first. A half-zero mask shows that a fully masked beat still takes its slot. A reserved kind code next to a ready group shows that the reserved code is skipped. A second group of the same kind during a running instruction tells unit blocking apart from group blocking. Two ready groups straddling the pointer show that the round-robin search starts after the last winner and not at group 0. Seeded random cycles then vary the ready flags, kinds and masks, including half-masked ones, so that all three units are loaded back to back and overlap. Every accept and every beat is compared with a reference computed from the rules above.

// File: rtl/simd_issue_pkg.sv
package simd_issue_pkg;

    typedef enum logic [1:0] {
        KIND_INT = 2'd0,
        KIND_F32 = 2'd1,
        KIND_F64 = 2'd2,
        KIND_RSV = 2'd3
    } op_kind_e;

    localparam int UNIT_CNT = 3;
    localparam int U_INT    = 0;
    localparam int U_F32    = 1;
    localparam int U_F64    = 2;

endpackage

// File: rtl/simd_rr_picker.sv
module simd_rr_picker #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          grant_any
);

    typedef struct packed {
        logic [IW-1:0] last;
    } rr_state_t;

    rr_state_t     st_d, st_q;
    logic [IW-1:0] cand;

    // search upward from the slot after the last winner
    always_comb begin
        st_d      = st_q;
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        cand      = '0;
        for (int i = 0; i < N; i++) begin
            cand = st_q.last + IW'(i + 1);
            if (!grant_any && req[cand]) begin
                grant[cand] = 1'b1;
                grant_idx   = cand;
                grant_any   = 1'b1;
            end
        end
        if (grant_any) begin
            st_d.last = grant_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0); // R6
    AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> grant_any); // R6

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
    parameter int LANES = 32,
    parameter int WIDTH = 16,
    parameter int NG    = 16,
    parameter int GW    = $clog2(NG),
    parameter int LW    = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GW-1:0]    load_group,
    input  logic [LANES-1:0] load_mask,
    output logic             valid,
    output logic [GW-1:0]    group,
    output logic [WIDTH-1:0] lane_en,
    output logic [LW-1:0]    lane_base,
    output logic             can_load,
    output logic [NG-1:0]    hold_grp
);

    localparam int BEATS = LANES / WIDTH;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    typedef struct packed {
        logic             valid;
        logic [GW-1:0]    group;
        logic [LANES-1:0] mask;
        logic [BW-1:0]    beat;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic        at_last;

    assign at_last  = st_q.beat == LAST_BEAT;
    assign can_load = !st_q.valid || at_last;
    assign valid    = st_q.valid;
    assign group    = st_q.group;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.group = load_group;
            st_d.mask  = load_mask;
            st_d.beat  = '0;
        end else if (st_q.valid) begin
            if (at_last) begin
                st_d.valid = 1'b0;
                st_d.beat  = '0;
            end else begin
                st_d.beat = st_q.beat + BW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // slice of the mask for the current beat
    always_comb begin
        lane_en = '0;
        for (int b = 0; b < BEATS; b++) begin
            if (st_q.beat == BW'(b)) begin
                lane_en = st_q.valid ? st_q.mask[b*WIDTH +: WIDTH] : '0;
            end
        end
        lane_base = LW'(int'(st_q.beat) * WIDTH);
    end

    // a group stays held until its last beat is on the outputs
    genvar g;
    generate
        for (g = 0; g < NG; g++) begin : g_hold
            assign hold_grp[g] = st_q.valid && !at_last && (st_q.group == GW'(g));
        end
    endgenerate

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> can_load); // R5
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid && lane_base == '0)); // R2
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !at_last && !load) |=> (st_q.valid && st_q.beat == $past(st_q.beat) + BW'(1))); // R4
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && at_last && !load) |=> !valid); // R4

endmodule

// File: rtl/simd_issue_seq.sv
module simd_issue_seq #(
    parameter int NUM_GROUPS = 16,
    parameter int LANES      = 32,
    parameter int WIDE_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int GW         = $clog2(NUM_GROUPS),
    parameter int LW         = $clog2(LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS-1:0]       grp_ready,
    input  logic [2*NUM_GROUPS-1:0]     grp_kind,
    input  logic [LANES*NUM_GROUPS-1:0] grp_mask,
    output logic [NUM_GROUPS-1:0]       grp_take,
    output logic                        int_valid,
    output logic [GW-1:0]               int_group,
    output logic [WIDE_W-1:0]           int_lane_en,
    output logic [LW-1:0]               int_lane_base,
    output logic                        f32_valid,
    output logic [GW-1:0]               f32_group,
    output logic [WIDE_W-1:0]           f32_lane_en,
    output logic [LW-1:0]               f32_lane_base,
    output logic                        f64_valid,
    output logic [GW-1:0]               f64_group,
    output logic [NARROW_W-1:0]         f64_lane_en,
    output logic [LW-1:0]               f64_lane_base
);

    import simd_issue_pkg::*;

    logic [UNIT_CNT-1:0]   unit_free;
    logic [UNIT_CNT-1:0]   unit_load;
    logic [NUM_GROUPS-1:0] hold_int, hold_f32, hold_f64, held;
    logic [NUM_GROUPS-1:0] eligible;
    logic [NUM_GROUPS-1:0] pick;
    logic [GW-1:0]         pick_idx;
    logic                  pick_any;
    op_kind_e              sel_kind;
    logic [LANES-1:0]      sel_mask;

    assign held = hold_int | hold_f32 | hold_f64;

    // a group is eligible when ready, not held, and its unit can take it
    always_comb begin
        eligible = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            case (op_kind_e'(grp_kind[2*g +: 2]))
                KIND_INT: eligible[g] = unit_free[U_INT];
                KIND_F32: eligible[g] = unit_free[U_F32];
                KIND_F64: eligible[g] = unit_free[U_F64];
                default:  eligible[g] = 1'b0;
            endcase
            eligible[g] = eligible[g] && grp_ready[g] && !held[g];
        end
    end

    simd_rr_picker #(.N(NUM_GROUPS), .IW(GW)) u_picker (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eligible),
        .grant     (pick),
        .grant_idx (pick_idx),
        .grant_any (pick_any)
    );

    assign grp_take = pick;

    // route the winner's kind and mask
    always_comb begin
        sel_kind = KIND_RSV;
        sel_mask = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (pick_idx == GW'(g)) begin
                sel_kind = op_kind_e'(grp_kind[2*g +: 2]);
                sel_mask = grp_mask[LANES*g +: LANES];
            end
        end
        unit_load        = '0;
        unit_load[U_INT] = pick_any && (sel_kind == KIND_INT);
        unit_load[U_F32] = pick_any && (sel_kind == KIND_F32);
        unit_load[U_F64] = pick_any && (sel_kind == KIND_F64);
    end

    simd_lane_unit #(.LANES(LANES), .WIDTH(WIDE_W), .NG(NUM_GROUPS), .GW(GW), .LW(LW)) u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (unit_load[U_INT]),
        .load_group (pick_idx),
        .load_mask  (sel_mask),
        .valid      (int_valid),
        .group      (int_group),
        .lane_en    (int_lane_en),
        .lane_base  (int_lane_base),
        .can_load   (unit_free[U_INT]),
        .hold_grp   (hold_int)
    );

    simd_lane_unit #(.LANES(LANES), .WIDTH(WIDE_W), .NG(NUM_GROUPS), .GW(GW), .LW(LW)) u_f32 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (unit_load[U_F32]),
        .load_group (pick_idx),
        .load_mask  (sel_mask),
        .valid      (f32_valid),
        .group      (f32_group),
        .lane_en    (f32_lane_en),
        .lane_base  (f32_lane_base),
        .can_load   (unit_free[U_F32]),
        .hold_grp   (hold_f32)
    );

    simd_lane_unit #(.LANES(LANES), .WIDTH(NARROW_W), .NG(NUM_GROUPS), .GW(GW), .LW(LW)) u_f64 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (unit_load[U_F64]),
        .load_group (pick_idx),
        .load_mask  (sel_mask),
        .valid      (f64_valid),
        .group      (f64_group),
        .lane_en    (f64_lane_en),
        .lane_base  (f64_lane_base),
        .can_load   (unit_free[U_F64]),
        .hold_grp   (hold_f64)
    );

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_take)); // R8
    AST_TAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_take & ~grp_ready) == '0); // R8
    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(unit_load) <= 1); // R10

    genvar gg;
    generate
        for (gg = 0; gg < NUM_GROUPS; gg++) begin : g_chk
            AST_NO_RSV_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
                grp_take[gg] |-> (grp_kind[2*gg +: 2] != 2'b11)); // R9
            AST_TAKE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                grp_take[gg] |-> !held[gg]); // R7
        end
    endgenerate

endmodule

// File: tb/simd_issue_seq_tb.sv
`timescale 1ns/1ps
module simd_issue_seq_tb;

    localparam int NG = 16;
    localparam int CLK_NS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG-1:0]     grp_ready = '0;
    logic [2*NG-1:0]   grp_kind = '0;
    logic [32*NG-1:0]  grp_mask = '0;
    logic [NG-1:0]     grp_take;
    logic              int_valid, f32_valid, f64_valid;
    logic [3:0]        int_group, f32_group, f64_group;
    logic [15:0]       int_lane_en, f32_lane_en;
    logic [7:0]        f64_lane_en;
    logic [4:0]        int_lane_base, f32_lane_base, f64_lane_base;

    int tests = 0;
    int fails = 0;

    // reference state per unit (0 int, 1 fp32, 2 fp64)
    int          mv[3];
    int          mg[3];
    logic [31:0] mm[3];
    int          mb[3];
    int          last_g;

    always #(CLK_NS/2) clk = ~clk;

    simd_issue_seq u_dut (.*);

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int unit_of(input logic [1:0] k);
        return (k == 2'd3) ? -1 : int'(k);
    endfunction

    function automatic int beats_of(input int u);
        return (u == 2) ? 4 : 2;
    endfunction

    function automatic int width_of(input int u);
        return (u == 2) ? 8 : 16;
    endfunction

    function automatic logic [NG-1:0] predict_take();
        logic [NG-1:0] elig = '0;
        logic [NG-1:0] res = '0;
        for (int g = 0; g < NG; g++) begin
            int  u = unit_of(grp_kind[2*g +: 2]);
            bit  blocked = 0;
            for (int v = 0; v < 3; v++)
                if (mv[v] != 0 && mg[v] == g && mb[v] != beats_of(v) - 1) blocked = 1;
            if (grp_ready[g] && u >= 0 && !blocked &&
                (mv[u] == 0 || mb[u] == beats_of(u) - 1))
                elig[g] = 1'b1;
        end
        for (int i = 1; i <= NG; i++) begin
            int c = (last_g + i) % NG;
            if (res == '0 && elig[c]) res[c] = 1'b1;
        end
        return res;
    endfunction

    task automatic check_unit(input int u, input logic v, input logic [3:0] grp,
                              input logic [15:0] en, input logic [4:0] base);
        string tag = (u == 2) ? "R3" : "R2";
        logic [15:0] exp_en;
        chk(v == (mv[u] != 0), $sformatf("%s unit%0d valid", tag, u), v, mv[u]);
        if (mv[u] != 0) begin
            exp_en = 16'((mm[u] >> (mb[u] * width_of(u))) & ((32'd1 << width_of(u)) - 1));
            chk(grp == 4'(mg[u]), $sformatf("R11 unit%0d group", u), grp, mg[u]);
            chk(en == exp_en, $sformatf("%s/R4 unit%0d lane_en", tag, u), en, exp_en);
            chk(base == 5'(mb[u] * width_of(u)), $sformatf("%s unit%0d base", tag, u),
                base, mb[u] * width_of(u));
        end
    endtask

    task automatic step(input logic [NG-1:0] rdy, input logic [2*NG-1:0] knd,
                        input logic [32*NG-1:0] msk);
        logic [NG-1:0] et;
        @(negedge clk);
        check_unit(0, int_valid, int_group, int_lane_en, int_lane_base);
        check_unit(1, f32_valid, f32_group, f32_lane_en, f32_lane_base);
        check_unit(2, f64_valid, f64_group, {8'h0, f64_lane_en}, f64_lane_base);
        grp_ready = rdy;
        grp_kind  = knd;
        grp_mask  = msk;
        #1;
        et = predict_take();
        chk(grp_take == et, "R6 accept vector", grp_take, et);
        chk($countones(grp_take) <= 1 && (grp_take & ~grp_ready) == '0,
            "R8 accept one-hot and ready", grp_take, et);
        for (int u = 0; u < 3; u++) begin
            if (mv[u] != 0) begin
                if (mb[u] == beats_of(u) - 1) mv[u] = 0;
                else mb[u]++;
            end
        end
        for (int g = 0; g < NG; g++) begin
            if (et[g]) begin
                int u = unit_of(knd[2*g +: 2]);
                mv[u] = 1; mg[u] = g; mm[u] = msk[32*g +: 32]; mb[u] = 0;
                last_g = g;
            end
        end
    endtask

    function automatic logic [2*NG-1:0] kind_at(input int g, input logic [1:0] k,
                                                input logic [2*NG-1:0] base);
        logic [2*NG-1:0] r = base;
        r[2*g +: 2] = k;
        return r;
    endfunction

    function automatic logic [32*NG-1:0] mask_at(input int g, input logic [31:0] m,
                                                 input logic [32*NG-1:0] base);
        logic [32*NG-1:0] r = base;
        r[32*g +: 32] = m;
        return r;
    endfunction

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [2*NG-1:0]  k;
        logic [32*NG-1:0] m;
        void'($urandom(32'h5EED_1234));
        for (int u = 0; u < 3; u++) begin mv[u] = 0; mg[u] = 0; mm[u] = '0; mb[u] = 0; end
        last_g = NG - 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!int_valid && !f32_valid && !f64_valid, "R1 units idle after reset",
            {int_valid, f32_valid, f64_valid}, 0);
        chk(grp_take == '0, "R1 no accept when nothing ready", grp_take, 0);

        // c0: group 5 integer, group 9 reserved
        k = kind_at(9, 2'd3, kind_at(5, 2'd0, '0));
        m = mask_at(5, 32'h0000_ABCD, '0);
        step((NG'(1) << 5) | (NG'(1) << 9), k, m);
        chk(grp_take == (NG'(1) << 5), "R6 first winner from group 0 upward", grp_take, 32);
        // c1: group 5 held, group 9 reserved
        step((NG'(1) << 5) | (NG'(1) << 9), k, m);
        chk(grp_take == '0, "R7/R9 held and reserved groups not accepted", grp_take, 0);
        chk(int_valid && int_group == 4'd5 && int_lane_en == 16'hABCD && int_lane_base == 5'd0,
            "R2 integer beat 0", int_lane_en, 16'hABCD);
        // c2: group 7 fp64 wins over group 5 (search starts after 5)
        k = kind_at(7, 2'd2, kind_at(5, 2'd0, '0));
        m = mask_at(7, 32'h1234_5678, mask_at(5, 32'h0000_ABCD, '0));
        step((NG'(1) << 5) | (NG'(1) << 7), k, m);
        chk(int_valid && int_lane_en == 16'h0 && int_lane_base == 5'd16,
            "R4 fully masked beat still spent", int_lane_en, 0);
        chk(grp_take == (NG'(1) << 7), "R6 round-robin passes group 5", grp_take, 128);
        // c3: group 5 integer again, unit idle
        k = kind_at(5, 2'd0, '0);
        m = mask_at(5, 32'hFFFF_0000, '0);
        step(NG'(1) << 5, k, m);
        chk(grp_take == (NG'(1) << 5), "R5 idle unit accepts", grp_take, 32);
        chk(f64_valid && f64_lane_en == 8'h78 && f64_lane_base == 5'd0,
            "R3 fp64 beat 0", f64_lane_en, 8'h78);
        // c4: group 2 integer while integer unit is mid-instruction
        k = kind_at(2, 2'd0, '0);
        m = mask_at(2, 32'h0F0F_F0F0, '0);
        step(NG'(1) << 2, k, m);
        chk(grp_take == '0, "R5 busy unit blocks other group", grp_take, 0);
        chk(int_valid && f64_valid, "R10 integer and fp64 overlap",
            {int_valid, f64_valid}, 3);
        chk(f64_lane_en == 8'h56 && f64_lane_base == 5'd8, "R3 fp64 beat 1", f64_lane_en, 8'h56);
        // c5: integer unit in final beat, group 2 follows without gap
        step(NG'(1) << 2, k, m);
        chk(grp_take == (NG'(1) << 2), "R5 accept during final beat", grp_take, 4);
        step('0, '0, '0);
        chk(int_valid && int_group == 4'd2 && int_lane_en == 16'hF0F0,
            "R11 back-to-back group on integer unit", int_group, 2);

        // seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [NG-1:0]    r;
            logic [2*NG-1:0]  kk;
            logic [32*NG-1:0] mk;
            r = NG'($urandom);
            kk = {$urandom, $urandom};
            for (int g = 0; g < NG; g++) begin
                logic [31:0] w = $urandom;
                case ($urandom % 4)
                    0: w[15:0] = '0;
                    1: w[31:16] = '0;
                    default: ;
                endcase
                mk[32*g +: 32] = w;
            end
            if ((n % 7) == 0) r = '0;
            step(r, kk, mk);
        end
        repeat (6) step('0, '0, '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule